// File: doc/BRIEF.md
# Extended Branch and Call Resolver

This block resolves one branch instruction of a 16-bit-word processor core that keeps the classic 8-bit conditional branch encodings. Each branch is two words: an opcode word and an offset word. The resolver receives both words, the address of the opcode word and the current flags. It evaluates the condition and computes the destination. For the call form it also asks for the return address to be pushed in the same cycle as the redirect.

Bit 15 of the opcode swaps the classic flag tests for an alternate set. That set contains "always" and "never". Bit 12 turns the branch into a relative call: the whole offset word becomes the displacement, and a taken call requests a push. A branch whose opcode upper byte is zero acts as a classic conditional branch with an 8-bit signed displacement.

The block does not hold the stack, handle the return instruction or fetch instructions. With the default configuration, results appear one clock after the request.

Top module: `brc_unit`

## Requirements
- R1: When opcode bit 15 is 0, the flag is selected by opcode bits 7:6 (00 picks flags[3] N, 01 picks flags[2] V, 10 picks flags[1] C, 11 picks flags[0] Z). The branch is taken exactly when that flag equals opcode bit 5, so 0x00F0 is taken on Z=1 and 0x00D0 on Z=0.
- R2: When opcode bit 15 is 1, the branch is taken exactly when opcode bits 7:5 are 111 ("always", for example 0x80F0), whatever the flags. Every other code in this set is never taken.
- R3: When opcode bit 12 is 0, a taken branch goes to pc + 2 plus the low 8 bits of the offset word, sign-extended.
- R4: When opcode bit 12 is 1, a taken branch goes to pc + 2 plus the full 16-bit offset word, sign-extended.
- R5: A branch that is not taken gives next_pc = pc + 2 and does not request a push.
- R6: A taken branch with opcode bit 12 set raises push_req together with taken, and push_data = pc + 2.
- R7: A request presented with in_valid is answered one cycle later with res_valid high. In a cycle without a result, res_valid, taken and push_req are low.
- R8: During and just after reset, res_valid, taken and push_req are low.
- R9: All address sums wrap modulo 2^ADDR_W.
- R10: Opcode bits 14, 13, 11:8 and 4:0 have no effect on taken, next_pc, push_req or push_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A branch is presented this cycle |
| op_word | input | WORD_W | Branch opcode word |
| ofs_word | input | WORD_W | Offset word that follows the opcode |
| pc_in | input | ADDR_W | Address of the opcode word |
| flags | input | 4 | {N, V, C, Z} |
| res_valid | output | 1 | A result is present |
| taken | output | 1 | The branch redirects the program counter |
| next_pc | output | ADDR_W | Address of the next instruction |
| push_req | output | 1 | Push the return address |
| push_data | output | ADDR_W | Return address to push |

## Verification
The redirect and the return-address push must happen in the same cycle whenever a call is taken. Any skew between them, or a push on an untaken call, is a fault. The bench drives every condition code under all sixteen flag values, in both condition sets and with both offset widths. This sweep produces taken calls, untaken calls and plain branches back to back. For each result the bench computes taken, the destination and the push request arithmetically, and it compares push_data with pc + 2 in the same sampled cycle in which taken and push_req are judged.

// File: rtl/brc_pkg.sv
package brc_pkg;
   localparam int FLAG_W   = 4;
   localparam int FLAG_N   = 3;
   localparam int FLAG_V   = 2;
   localparam int FLAG_C   = 1;
   localparam int FLAG_Z   = 0;
   localparam int BIT_ALT  = 15;
   localparam int BIT_LONG = 12;
   localparam int BIT_POL  = 5;
   localparam int SEL_HI   = 7;
   localparam int SEL_LO   = 6;
   localparam int BR_WORDS = 2;

   typedef enum logic [1:0] {
      SEL_NEG = 2'b00,
      SEL_OVF = 2'b01,
      SEL_CRY = 2'b10,
      SEL_ZER = 2'b11
   } cond_sel_e;

   function automatic int flag_index(input cond_sel_e s);
      case (s)
         SEL_NEG: return FLAG_N;
         SEL_OVF: return FLAG_V;
         SEL_CRY: return FLAG_C;
         default: return FLAG_Z;
      endcase
   endfunction
endpackage

// File: rtl/brc_cond.sv
module brc_cond
   import brc_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter bit ALT_EN = 1'b1
) (
   input  logic [WORD_W-1:0] op_word,
   input  logic [FLAG_W-1:0] flags,
   output logic              cond_true
);
   cond_sel_e sel;
   logic      classic_true;

   assign sel          = cond_sel_e'(op_word[SEL_HI:SEL_LO]);
   assign classic_true = (flags[flag_index(sel)] == op_word[BIT_POL]);

   generate
      if (ALT_EN) begin : g_alt
         logic alt_true;
         // alternate set: only code 111 ("always") is taken
         assign alt_true  = (op_word[SEL_HI:BIT_POL] == 3'b111);
         assign cond_true = op_word[BIT_ALT] ? alt_true : classic_true;
      end else begin : g_classic
         assign cond_true = classic_true;
      end
   endgenerate
endmodule

// File: rtl/brc_target.sv
module brc_target
   import brc_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [WORD_W-1:0] ofs_word,
   input  logic              is_long,
   output logic [ADDR_W-1:0] seq_pc,
   output logic [ADDR_W-1:0] tgt_pc
);
   localparam int SHORT_W = WORD_W / 2;

   logic [ADDR_W-1:0] short_ext;
   logic [ADDR_W-1:0] long_ext;

   assign short_ext = {{(ADDR_W-SHORT_W){ofs_word[SHORT_W-1]}}, ofs_word[SHORT_W-1:0]};

   generate
      if (ADDR_W > WORD_W) begin : g_wide
         assign long_ext = {{(ADDR_W-WORD_W){ofs_word[WORD_W-1]}}, ofs_word};
      end else begin : g_same
         assign long_ext = ofs_word;
      end
   endgenerate

   assign seq_pc = pc_in + ADDR_W'(BR_WORDS);
   assign tgt_pc = seq_pc + (is_long ? long_ext : short_ext);
endmodule

// File: rtl/brc_unit.sv
module brc_unit
   import brc_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int ADDR_W  = 16,
   parameter bit ALT_EN  = 1'b1,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] op_word,
   input  logic [WORD_W-1:0] ofs_word,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [3:0]        flags,
   output logic              res_valid,
   output logic              taken,
   output logic [ADDR_W-1:0] next_pc,
   output logic              push_req,
   output logic [ADDR_W-1:0] push_data
);
   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("brc_unit: WORD_W must be 16");
      end
      if (ADDR_W < WORD_W) begin : g_bad_addr
         $error("brc_unit: ADDR_W must be at least WORD_W");
      end
   endgenerate

   logic              cond_true;
   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] tgt_pc;
   logic              is_long;
   logic              c_taken;
   logic              c_push;
   logic [ADDR_W-1:0] c_next;

   brc_cond #(.WORD_W(WORD_W), .ALT_EN(ALT_EN)) u_cond (
      .op_word  (op_word),
      .flags    (flags),
      .cond_true(cond_true)
   );

   assign is_long = op_word[BIT_LONG];

   brc_target #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_target (
      .pc_in   (pc_in),
      .ofs_word(ofs_word),
      .is_long (is_long),
      .seq_pc  (seq_pc),
      .tgt_pc  (tgt_pc)
   );

   assign c_taken = in_valid & cond_true;
   assign c_push  = c_taken & is_long;
   assign c_next  = cond_true ? tgt_pc : seq_pc;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_valid <= 1'b0;
               taken     <= 1'b0;
               push_req  <= 1'b0;
               next_pc   <= '0;
               push_data <= '0;
            end else begin
               res_valid <= in_valid;
               taken     <= c_taken;
               push_req  <= c_push;
               next_pc   <= c_next;
               push_data <= seq_pc;
            end
         end

         a_r7_answer: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> res_valid);
         a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !res_valid);
         a_r6_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (push_data == $past(pc_in) + ADDR_W'(BR_WORDS)));
         a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !cond_true) |=> (next_pc == $past(pc_in) + ADDR_W'(BR_WORDS)));
      end else begin : g_comb
         assign res_valid = in_valid;
         assign taken     = c_taken;
         assign push_req  = c_push;
         assign next_pc   = c_next;
         assign push_data = seq_pc;
      end
   endgenerate

   a_r6_push_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      push_req |-> taken);
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!taken && !push_req));
   a_r5_untaken_no_push: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !taken) |-> !push_req);
endmodule

// File: tb/test_brc_unit.sv
`timescale 1ns/1ps
module test_brc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] op_word = '0;
   logic [15:0] ofs_word = '0;
   logic [15:0] pc_in = '0;
   logic [3:0]  flags = '0;
   logic        res_valid;
   logic        taken;
   logic [15:0] next_pc;
   logic        push_req;
   logic [15:0] push_data;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   brc_unit i_brc_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_word(op_word),
      .ofs_word(ofs_word), .pc_in(pc_in), .flags(flags),
      .res_valid(res_valid), .taken(taken), .next_pc(next_pc),
      .push_req(push_req), .push_data(push_data)
   );

   task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h (op=%h ofs=%h pc=%h fl=%b)",
                  tag, what, act, exp, op_word, ofs_word, pc_in, flags);
      end
   endtask

   // drive one branch at a negedge, judge it one clock later
   task automatic run_one(input logic [15:0] op, input logic [15:0] ofs,
                          input logic [15:0] pc, input logic [3:0] fl, input string extra);
      logic        e_cond, e_taken, e_push, is_long;
      logic [15:0] disp, seq, e_next;
      int          fi;
      string       ctag, ttag, ptag;
      op_word = op; ofs_word = ofs; pc_in = pc; flags = fl; in_valid = 1'b1;
      fi = 3 - int'(op[7:6]);                       // R1 flag choice
      if (op[15]) e_cond = (op[7:5] == 3'b111);      // R2
      else        e_cond = (fl[fi] == op[5]);        // R1
      is_long = op[12];
      disp    = is_long ? ofs : {{8{ofs[7]}}, ofs[7:0]};
      seq     = pc + 16'd2;
      e_taken = e_cond;
      e_next  = e_cond ? seq + disp : seq;
      e_push  = e_cond & is_long;
      ctag = op[15] ? "R2" : "R1";
      ttag = !e_cond ? "R5" : (is_long ? "R4" : "R3");
      ptag = e_push ? "R6" : "R5";
      @(negedge clk);
      chk("R7", "res_valid", {15'd0, res_valid}, 16'd1);
      chk({ctag, extra}, "taken", {15'd0, taken}, {15'd0, e_taken});
      chk({ttag, extra}, "next_pc", next_pc, e_next);
      chk({ptag, extra}, "push_req", {15'd0, push_req}, {15'd0, e_push});
      if (e_push) chk({"R6", extra}, "push_data", push_data, seq);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [7:0] hi_set [6];
      int k;
      hi_set[0] = 8'h00; hi_set[1] = 8'h80; hi_set[2] = 8'h10;
      hi_set[3] = 8'h90; hi_set[4] = 8'h6E; hi_set[5] = 8'hFB;
      k = 0;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8", "res_valid", {15'd0, res_valid}, 16'd0);
      chk("R8", "taken", {15'd0, taken}, 16'd0);
      chk("R8", "push_req", {15'd0, push_req}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", "res_valid after release", {15'd0, res_valid}, 16'd0);

      // examples: classic beq/bne and always/call
      run_one(16'h00F0, 16'h00FB, 16'hE9C7, 4'b0001, "");
      run_one(16'h00D0, 16'h00FB, 16'hE9C7, 4'b0001, "");
      run_one(16'h80F0, 16'h00EA, 16'hE9C2, 4'b0000, "");
      run_one(16'h90F0, 16'h07A9, 16'hE9BE, 4'b1111, "");
      run_one(16'h90F0, 16'h07A3, 16'hE9C4, 4'b0000, "");
      run_one(16'h90D0, 16'h07A3, 16'hE9C4, 4'b0000, "");

      // sweep: opcode upper bits x condition code x all flag values
      for (int h = 0; h < 6; h++) begin
         for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
               logic [15:0] op, ofs, pc;
               op  = {hi_set[h], 3'(c), (h >= 4) ? 5'b01011 : 5'b10000};
               ofs = 16'(k * 16'h1357 + 16'h00F0);
               pc  = 16'(k * 16'h0B3D + 16'h1000);
               // R10 applies to the vectors with stray opcode bits (h >= 4)
               run_one(op, ofs, pc, 4'(f), (h >= 4) ? "/R10" : "");
               k++;
            end
         end
      end

      // R10: same branch with and without stray bits must match
      run_one(16'h00B0, 16'h0040, 16'h2000, 4'b0010, "/R10");
      run_one(16'h6FBF, 16'h0040, 16'h2000, 4'b0010, "/R10");

      // R9: wrap-around at both ends of the address space
      run_one(16'h80F0, 16'h0001, 16'hFFFE, 4'b0000, "/R9");
      run_one(16'h80F0, 16'h0080, 16'h0010, 4'b0000, "/R9");
      run_one(16'h90F0, 16'h8000, 16'h1000, 4'b0000, "/R9");
      run_one(16'h90F0, 16'h7FFF, 16'hFFF0, 4'b0000, "/R9");
      run_one(16'h00F0, 16'h007F, 16'hFFFF, 4'b0001, "/R9");

      // R7: idle cycles give no result
      in_valid = 1'b0;
      op_word  = 16'h90F0;
      @(negedge clk);
      chk("R7", "idle res_valid", {15'd0, res_valid}, 16'd0);
      chk("R7", "idle taken", {15'd0, taken}, 16'd0);
      chk("R7", "idle push_req", {15'd0, push_req}, 16'd0);
      @(negedge clk);
      chk("R7", "idle res_valid 2", {15'd0, res_valid}, 16'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule